// File: doc/BRIEF.md
# Reset Cause Sequencer with Time-out and Power-down Flags

This block sequences the internal reset of a small microcontroller. It watches three reset sources: a power-on request, a low-voltage detector output and a watchdog expiry. It also watches the current power mode and the selected system clock source. When any source fires, the internal reset is asserted and held for a start-up interval whose length depends on the clock source. When the interval ends, the reset is released and one-cycle clear strobes go to the program counter, the stack pointer, the interrupt enables, the watchdog and the timers.

The block also keeps two status flags, `to_flag_o` (time-out) and `pd_flag_o` (power-down). Each reset cause, in each power mode, updates them in its own way. Two instruction strobes from the core also update them: one when a sleep/idle instruction is accepted, and one for a clear-watchdog instruction. The oscillators, the watchdog counter and the core itself are outside this block.

Top module: `rstseq_top`

## Requirements
- R1: While `rst_n` is low, the internal reset is held (`rst_hold_o`=1), both flags read 0 and every clear strobe is 0.
- R2: A power-on request clears both the time-out flag and the power-down flag on the clock edge that samples it.
- R3: A low-voltage request that is not accompanied by a power-on request leaves both flags unchanged, in every power mode.
- R4: A watchdog expiry alone in normal (`pmode_i`=00) or slow (01) mode sets the time-out flag to 1 and leaves the power-down flag unchanged.
- R5: A watchdog expiry alone in idle (10) or sleep (11) mode sets both flags to 1.
- R6: When causes coincide, power-on is taken over low-voltage, and low-voltage is taken over watchdog. Both the flag update and the strobe set follow the winner.
- R7: After the sampling edge, the internal reset stays high for exactly 16 cycles with `clksel_i`=00 (fast internal RC), 128 cycles with 01 or 11 (crystal), and 2 cycles with 10 (slow internal RC).
- R8: Any cause sampled while the reset is held restarts the full hold interval, and no strobes are issued for the interrupted interval. This also holds when the new cause lands on what would have been the last hold cycle.
- R9: The clear strobes are single-cycle pulses, issued in the first cycle with `rst_hold_o` low. After a power-on, low-voltage or run-mode watchdog reset, all five strobes fire. Strobe vector order, bit 0 upward: pc, sp, int, wdt, tmr.
- R10: After a watchdog reset taken in idle or sleep mode, only the program counter and stack pointer strobes fire.
- R11: Outside the hold, `sleep_ack_i` sets the power-down flag, and `clrwdt_i` clears both flags, taking precedence over `sleep_ack_i`. Both instruction strobes are ignored while the reset is held and whenever a reset cause is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_i | input | 1 | Power-on reset request |
| lvr_i | input | 1 | Low-voltage reset request |
| wdt_to_i | input | 1 | Watchdog expiry |
| pmode_i | input | 2 | Power mode: 00 normal, 01 slow, 10 idle, 11 sleep |
| clksel_i | input | 2 | Clock source: 00 fast RC, 01 crystal, 10 slow RC, 11 crystal |
| sleep_ack_i | input | 1 | Sleep/idle instruction accepted |
| clrwdt_i | input | 1 | Clear-watchdog instruction |
| rst_hold_o | output | 1 | Internal reset held |
| to_flag_o | output | 1 | Time-out status flag |
| pd_flag_o | output | 1 | Power-down status flag |
| clr_pc_o | output | 1 | Program counter clear strobe |
| clr_sp_o | output | 1 | Stack pointer clear strobe |
| clr_int_o | output | 1 | Interrupt enable clear strobe |
| clr_wdt_o | output | 1 | Watchdog clear strobe |
| clr_tmr_o | output | 1 | Timer clear strobe |

## Verification
Three kinds of event can fall into one clock cycle: the end of a hold interval, a fresh reset cause, and a core instruction strobe. The bench drives a power-on request and then places a second cause exactly on the last hold cycle. It judges the result by the absence of strobes at the original release time and by a release exactly one full interval after the second cause. It also raises several causes together, and raises causes together with `clrwdt_i` or `sleep_ack_i`. It compares the flags against the cause-priority rules, and compares the strobe mask and cycle of each release against a queue of expected releases.

// File: rtl/rstseq_pkg.sv
// Package: shared encodings for the reset sequencer.
// Assumes power-mode bit 1 marks the low-power modes (idle, sleep).
package rstseq_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_SLOW   = 2'b01,
        PM_IDLE   = 2'b10,
        PM_SLEEP  = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        CK_FAST_RC = 2'b00,
        CK_XTAL    = 2'b01,
        CK_SLOW_RC = 2'b10,
        CK_XTAL_B  = 2'b11
    } clksrc_e;

    typedef enum logic [1:0] {
        CA_POWERON = 2'b00,
        CA_LOWVOLT = 2'b01,
        CA_WDT_RUN = 2'b10,
        CA_WDT_LOW = 2'b11
    } cause_e;

    localparam int unsigned STB_W   = 5;
    localparam int unsigned STB_PC  = 0;
    localparam int unsigned STB_SP  = 1;
    localparam int unsigned STB_INT = 2;
    localparam int unsigned STB_WDT = 3;
    localparam int unsigned STB_TMR = 4;

    // Strobe set for each cause: the low-power watchdog wake clears pc/sp only.
    function automatic logic [STB_W-1:0] strobe_mask(cause_e c);
        logic [STB_W-1:0] m;
        m = '1;
        if (c == CA_WDT_LOW) begin
            m = '0;
            m[STB_PC] = 1'b1;
            m[STB_SP] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic is_low_power(pmode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/rstseq_arb.sv
// Module: rstseq_arb
// Priority-encodes the reset sources into one cause.
// Order: power-on, then low-voltage, then watchdog. The watchdog cause
// is split by power mode. Purely combinational.
module rstseq_arb
    import rstseq_pkg::*;
(
    input  logic   por_i,
    input  logic   lvr_i,
    input  logic   wdt_i,
    input  pmode_e pmode_i,
    output logic   hit_o,
    output cause_e cause_o
);

    // Any source present this cycle.
    assign hit_o = por_i | lvr_i | wdt_i;

    // Pick the highest-priority source.
    always_comb begin
        if (por_i)
            cause_o = CA_POWERON;
        else if (lvr_i)
            cause_o = CA_LOWVOLT;
        else if (is_low_power(pmode_i))
            cause_o = CA_WDT_LOW;
        else
            cause_o = CA_WDT_RUN;
    end

endmodule

// File: rtl/rstseq_timer.sv
// Module: rstseq_timer
// Start-up hold counter. It holds the internal reset for a clock-source
// dependent number of cycles after the last cause.
// Assumes clksel is stable while the hold is active, and every hold
// length is at least 1.
module rstseq_timer
    import rstseq_pkg::*;
#(
    parameter int unsigned HOLD_FAST = 16,
    parameter int unsigned HOLD_XTAL = 128,
    parameter int unsigned HOLD_SLOW = 2
)(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    restart_i,
    input  clksrc_e clksel_i,
    output logic    hold_o,
    output logic    release_o
);

    localparam int unsigned MAX_A    = (HOLD_FAST > HOLD_XTAL) ? HOLD_FAST : HOLD_XTAL;
    localparam int unsigned MAX_HOLD = (MAX_A > HOLD_SLOW) ? MAX_A : HOLD_SLOW;
    localparam int unsigned CNT_W    = $clog2(MAX_HOLD + 1);

    logic             hold_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    // Last count value of the hold for the selected clock source.
    always_comb begin
        case (clksel_i)
            CK_FAST_RC: last_cnt = CNT_W'(HOLD_FAST - 1);
            CK_SLOW_RC: last_cnt = CNT_W'(HOLD_SLOW - 1);
            default:    last_cnt = CNT_W'(HOLD_XTAL - 1);
        endcase
    end

    // Release happens on the last count, unless a new cause restarts the hold.
    assign release_o = hold_q && !restart_i && (cnt_q == last_cnt);
    assign hold_o    = hold_q;

    // Hold flag and count: restart on a cause, count up, drop on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
            cnt_q  <= '0;
        end else if (restart_i) begin
            hold_q <= 1'b1;
            cnt_q  <= '0;
        end else if (hold_q) begin
            if (cnt_q == last_cnt) begin
                hold_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rstseq_flags.sv
// Module: rstseq_flags
// Time-out and power-down status flags.
// Reset causes take precedence over instruction strobes. Instruction
// strobes act only while the internal reset is released.
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hit_i,
    input  cause_e cause_i,
    input  logic   hold_i,
    input  logic   sleep_ack_i,
    input  logic   clrwdt_i,
    output logic   to_o,
    output logic   pd_o
);

    logic to_q, pd_q;

    // Flag update by cause first, then by instruction strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q <= 1'b0;
            pd_q <= 1'b0;
        end else if (hit_i) begin
            case (cause_i)
                CA_POWERON: begin to_q <= 1'b0; pd_q <= 1'b0; end
                CA_WDT_RUN: begin to_q <= 1'b1; end
                CA_WDT_LOW: begin to_q <= 1'b1; pd_q <= 1'b1; end
                default:    ;
            endcase
        end else if (!hold_i) begin
            if (clrwdt_i) begin
                to_q <= 1'b0;
                pd_q <= 1'b0;
            end else if (sleep_ack_i) begin
                pd_q <= 1'b1;
            end
        end
    end

    assign to_o = to_q;
    assign pd_o = pd_q;

endmodule

// File: rtl/rstseq_strobe.sv
// Module: rstseq_strobe
// Remembers the latest reset cause and emits one-cycle clear strobes on
// release. The pulses are registered, so they appear in the first
// released cycle.
module rstseq_strobe
    import rstseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  cause_e           cause_i,
    input  logic             release_i,
    output logic [STB_W-1:0] stb_o
);

    cause_e           kind_q;
    logic [STB_W-1:0] mask;

    // Latch the winning cause of the latest request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kind_q <= CA_POWERON;
        else if (hit_i)
            kind_q <= cause_i;
    end

    assign mask = strobe_mask(kind_q);

    for (genvar b = 0; b < STB_W; b++) begin : g_stb
        // One pulse per target when the hold ends.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stb_o[b] <= 1'b0;
            else
                stb_o[b] <= release_i & mask[b];
        end
    end

endmodule

// File: rtl/rstseq_top.sv
// Module: rstseq_top
// Reset cause sequencer: arbitration, start-up hold, status flags and
// clear strobes.
// Assumes the source inputs are synchronous to clk.
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned HOLD_FAST = 16,
    parameter int unsigned HOLD_XTAL = 128,
    parameter int unsigned HOLD_SLOW = 2
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_i,
    input  logic       lvr_i,
    input  logic       wdt_to_i,
    input  logic [1:0] pmode_i,
    input  logic [1:0] clksel_i,
    input  logic       sleep_ack_i,
    input  logic       clrwdt_i,
    output logic       rst_hold_o,
    output logic       to_flag_o,
    output logic       pd_flag_o,
    output logic       clr_pc_o,
    output logic       clr_sp_o,
    output logic       clr_int_o,
    output logic       clr_wdt_o,
    output logic       clr_tmr_o
);

    logic             hit;
    cause_e           cause;
    logic             hold;
    logic             release_now;
    logic [STB_W-1:0] stb;

    rstseq_arb u_arb (
        .por_i   (por_i),
        .lvr_i   (lvr_i),
        .wdt_i   (wdt_to_i),
        .pmode_i (pmode_e'(pmode_i)),
        .hit_o   (hit),
        .cause_o (cause)
    );

    rstseq_timer #(
        .HOLD_FAST (HOLD_FAST),
        .HOLD_XTAL (HOLD_XTAL),
        .HOLD_SLOW (HOLD_SLOW)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (hit),
        .clksel_i  (clksrc_e'(clksel_i)),
        .hold_o    (hold),
        .release_o (release_now)
    );

    rstseq_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .cause_i     (cause),
        .hold_i      (hold),
        .sleep_ack_i (sleep_ack_i),
        .clrwdt_i    (clrwdt_i),
        .to_o        (to_flag_o),
        .pd_o        (pd_flag_o)
    );

    rstseq_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .cause_i   (cause),
        .release_i (release_now),
        .stb_o     (stb)
    );

    assign rst_hold_o = hold;
    assign clr_pc_o   = stb[STB_PC];
    assign clr_sp_o   = stb[STB_SP];
    assign clr_int_o  = stb[STB_INT];
    assign clr_wdt_o  = stb[STB_WDT];
    assign clr_tmr_o  = stb[STB_TMR];

endmodule

// File: rtl/rstseq_chk.sv
// Module: rstseq_chk
// Port-level properties of the reset sequencer, bound to rstseq_top.
module rstseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_i,
    input logic       lvr_i,
    input logic       wdt_to_i,
    input logic [1:0] pmode_i,
    input logic       rst_hold_o,
    input logic       to_flag_o,
    input logic       pd_flag_o,
    input logic       clr_pc_o,
    input logic       clr_sp_o,
    input logic       clr_int_o,
    input logic       clr_wdt_o,
    input logic       clr_tmr_o
);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rst_hold_o && !to_flag_o && !pd_flag_o && !clr_pc_o));

    assert_poweron_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        por_i |=> (!to_flag_o && !pd_flag_o));

    assert_lowvolt_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvr_i && !por_i) |=> ($stable(to_flag_o) && $stable(pd_flag_o)));

    assert_wdt_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_to_i && !por_i && !lvr_i && !pmode_i[1]) |=> (to_flag_o && $stable(pd_flag_o)));

    assert_wdt_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_to_i && !por_i && !lvr_i && pmode_i[1]) |=> (to_flag_o && pd_flag_o));

    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (por_i || lvr_i || wdt_to_i) |=> (rst_hold_o && !clr_pc_o));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pc_o |=> !clr_pc_o);

    assert_on_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pc_o |-> (!rst_hold_o && $past(rst_hold_o)));

    assert_pc_sp_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pc_o == clr_sp_o);

    assert_subset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_int_o || clr_wdt_o || clr_tmr_o) |-> clr_pc_o);

    assert_hold_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_hold_o && !por_i && !lvr_i && !wdt_to_i) |=> ($stable(to_flag_o) && $stable(pd_flag_o)));

endmodule

bind rstseq_top rstseq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_i      (por_i),
    .lvr_i      (lvr_i),
    .wdt_to_i   (wdt_to_i),
    .pmode_i    (pmode_i),
    .rst_hold_o (rst_hold_o),
    .to_flag_o  (to_flag_o),
    .pd_flag_o  (pd_flag_o),
    .clr_pc_o   (clr_pc_o),
    .clr_sp_o   (clr_sp_o),
    .clr_int_o  (clr_int_o),
    .clr_wdt_o  (clr_wdt_o),
    .clr_tmr_o  (clr_tmr_o)
);

// File: tb/sim_rstseq_top.sv
// Scoreboard bench: the driver queues the expected releases and a
// monitor matches each strobe burst against them.
module sim_rstseq_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, por, lvr, wdt, sack, cwdt;
    logic [1:0] pmode, clksel;
    logic       hold, to_f, pd_f, c_pc, c_sp, c_int, c_wdt, c_tmr;

    rstseq_top u0 (
        .clk(clk), .rst_n(rst_n), .por_i(por), .lvr_i(lvr), .wdt_to_i(wdt),
        .pmode_i(pmode), .clksel_i(clksel), .sleep_ack_i(sack), .clrwdt_i(cwdt),
        .rst_hold_o(hold), .to_flag_o(to_f), .pd_flag_o(pd_f),
        .clr_pc_o(c_pc), .clr_sp_o(c_sp), .clr_int_o(c_int),
        .clr_wdt_o(c_wdt), .clr_tmr_o(c_tmr)
    );

    localparam logic [4:0] M_ALL  = 5'h1F;
    localparam logic [4:0] M_PCSP = 5'h03;

    typedef struct {
        int         at;
        logic [4:0] mask;
        string      req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int hold_len(logic [1:0] s);
        case (s)
            2'b00:   return 16;
            2'b10:   return 2;
            default: return 128;
        endcase
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor: every strobe burst must match the head of the queue.
    always @(negedge clk) begin
        logic [4:0] s;
        exp_t       e;
        s = {c_tmr, c_wdt, c_int, c_sp, c_pc};
        if (rst_n === 1'b1 && s != 5'h00) begin
            if (q.size() == 0) begin
                check(1'b0, "R8/R9", "unexpected strobe mask", int'(s), 0);
            end else begin
                e = q.pop_front();
                check(cyc == e.at, e.req, "release cycle", cyc, e.at);
                check(s == e.mask, e.req, "strobe mask", int'(s), int'(e.mask));
            end
        end
    end

    // Present causes at a negedge; they are sampled at the next edge.
    task automatic fire(bit p, bit l, bit w, logic [1:0] pm, bit push,
                        logic [4:0] mask, string req);
        por = p; lvr = l; wdt = w; pmode = pm;
        @(posedge clk);
        #1;
        if (push) q.push_back('{cyc + hold_len(clksel), mask, req});
        @(negedge clk);
        por = 0; lvr = 0; wdt = 0;
    endtask

    task automatic wait_done();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(bit s, bit c);
        sack = s; cwdt = c;
        @(negedge clk);
        sack = 0; cwdt = 0;
        @(negedge clk);
    endtask

    task automatic flags(bit t, bit p, string req);
        check(to_f == t, req, "to flag", int'(to_f), int'(t));
        check(pd_f == p, req, "pd flag", int'(pd_f), int'(p));
    endtask

    initial begin
        rst_n = 0; por = 0; lvr = 0; wdt = 0; sack = 0; cwdt = 0;
        pmode = 2'b00; clksel = 2'b00;
        repeat (3) @(negedge clk);
        // R1 reset state
        flags(0, 0, "R1");
        check(hold == 1'b1, "R1", "hold in reset", int'(hold), 1);
        check(c_pc == 1'b0, "R1", "strobe in reset", int'(c_pc), 0);
        rst_n = 1;
        q.push_back('{cyc + 16, M_ALL, "R1"});
        wait_done();
        check(hold == 1'b0, "R9", "hold after release", int'(hold), 0);

        // R11 instruction strobes, clrwdt wins over sleep_ack
        pulse(1, 0); flags(0, 1, "R11");
        pulse(0, 1); flags(0, 0, "R11");
        pulse(1, 0); pulse(1, 1); flags(0, 0, "R11");

        // R4 watchdog in run mode
        pulse(1, 0);
        fire(0, 0, 1, 2'b01, 1, M_ALL, "R4");
        flags(1, 1, "R4");
        check(hold == 1'b1, "R7", "hold during interval", int'(hold), 1);
        pulse(0, 1);
        flags(1, 1, "R11");
        wait_done();
        pulse(0, 1); flags(0, 0, "R11");
        fire(0, 0, 1, 2'b00, 1, M_ALL, "R4");
        flags(1, 0, "R4");
        wait_done();

        // R5/R10 watchdog in sleep and idle
        fire(0, 0, 1, 2'b11, 1, M_PCSP, "R10");
        flags(1, 1, "R5");
        wait_done();
        pulse(0, 1);
        fire(0, 0, 1, 2'b10, 1, M_PCSP, "R10");
        flags(1, 1, "R5");
        wait_done();

        // R3 low-voltage keeps flags
        fire(0, 1, 0, 2'b01, 1, M_ALL, "R3");
        flags(1, 1, "R3");
        wait_done();
        pulse(0, 1);
        fire(0, 1, 0, 2'b11, 1, M_ALL, "R3");
        flags(0, 0, "R3");
        wait_done();

        // R2 power-on clears, even alongside an instruction strobe
        pulse(1, 0);
        sack = 1;
        fire(1, 0, 0, 2'b00, 1, M_ALL, "R2");
        sack = 0;
        flags(0, 0, "R2");
        wait_done();

        // R6 priority
        pulse(1, 0);
        fire(0, 1, 1, 2'b11, 1, M_ALL, "R6");
        flags(0, 1, "R6");
        wait_done();
        fire(1, 1, 1, 2'b11, 1, M_ALL, "R6");
        flags(0, 0, "R6");
        wait_done();

        // R7 hold lengths per clock source
        clksel = 2'b01; fire(1, 0, 0, 2'b00, 1, M_ALL, "R7"); wait_done();
        clksel = 2'b10; fire(1, 0, 0, 2'b00, 1, M_ALL, "R7"); wait_done();
        clksel = 2'b11; fire(1, 0, 0, 2'b00, 1, M_ALL, "R7"); wait_done();
        clksel = 2'b00;

        // R8 restart mid-interval
        fire(1, 0, 0, 2'b00, 0, M_ALL, "R8");
        repeat (6) @(negedge clk);
        fire(0, 0, 1, 2'b10, 1, M_PCSP, "R8");
        wait_done();
        // R8 restart on the would-be release cycle
        fire(1, 0, 0, 2'b00, 0, M_ALL, "R8");
        repeat (15) @(negedge clk);
        check(hold == 1'b1, "R8", "hold before last cycle", int'(hold), 1);
        fire(0, 1, 0, 2'b00, 1, M_ALL, "R8");
        wait_done();
        check(hold == 1'b0, "R8", "hold after restart", int'(hold), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule